// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Receive Queue

This block takes an asynchronous serial line and turns it into characters. An external oversample tick arrives sixteen times per bit period. The receiver looks for a falling edge on the line and confirms the start bit with a mid-bit sample. It then samples the data bits, the optional parity bit and the first stop bit at the centre of each bit. Each finished character goes into a two-entry queue. Every queue entry keeps the character, its ninth bit, its stop-bit status and its parity status, so the error flags always describe the character at the head of the queue.

A host reads the head entry with a single read strobe, and each strobe pops the queue. The ninth bit and the error flags are therefore visible next to the low byte until that read. If both queue entries are full, one more complete character can wait in the shift stage. A new start bit seen in that state is reported as an overrun, and the waiting character is lost. Clearing the enable empties everything. An address-filter mode discards every frame that is not marked as an address frame.

Top module: `serial_rx_fifo2`

## Requirements
- R1: The queue holds two entries and returns them in arrival order. A read strobe while the queue holds data removes the head entry at that clock edge. A read strobe while the queue is empty changes nothing.
- R2: The character size code selects the bit count: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8 and 7 gives 9 bits; codes 4 to 6 are taken as 8 bits. Data bits above the selected size read as 0, and `rd_bit8` reads as 0 unless the size is 9 bits.
- R3: `rx_ready` is 1 exactly when the queue holds at least one unread entry. After reset the queue is empty and all flags and `rd_data` are 0.
- R4: `frame_err` belongs to the head entry. It is 1 when that character's first stop bit was sampled as 0. Only the first stop bit is checked.
- R5: Parity mode 2'b10 expects even parity and 2'b11 expects odd parity over the data bits and the parity bit. Modes 2'b00 and 2'b01 send no parity bit and check none. `parity_err` belongs to the head entry. The mode is captured when the start bit is confirmed.
- R6: If both entries are full, a complete character waits in the shift stage, and a new start bit is confirmed with no read in that cycle, then `overrun` goes to 1 and the waiting character is discarded. `overrun` goes back to 0 on the next read that pops the queue.
- R7: While `rx_en` is 0 the receiver ignores the line. At the first clock edge with `rx_en` at 0, the queue and the shift stage are emptied and `rx_ready`, `frame_err`, `parity_err` and `overrun` go to 0.
- R8: With `addr_filter` at 1, a frame counts as an address frame in these cases: in 9-bit mode, its ninth bit is 1; in 5- to 8-bit modes, its first stop bit is 1. Every other frame is discarded and never enters the queue. The filter setting is captured when the start bit is confirmed.
- R9: A start bit is a 1-to-0 change of the line between two ticks. It is confirmed by a sample taken 8 ticks later. If that sample is 1, the receiver goes back to idle and produces no character.
- R10: After the start bit is confirmed, data bits are sampled every 16 ticks, least significant bit first. The parity bit follows when parity is enabled, and the first stop bit comes last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial line, idle high, synchronised inside |
| rx_en | input | 1 | Receiver enable; 0 flushes the queue |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| char_size | input | 3 | Character size code (R2) |
| parity_mode | input | 2 | Parity mode (R5) |
| addr_filter | input | 1 | Discard frames that are not address frames |
| rd_strobe | input | 1 | Read of the head entry; pops the queue |
| rd_data | output | 8 | Low eight data bits of the head entry |
| rd_bit8 | output | 1 | Ninth data bit of the head entry |
| rx_ready | output | 1 | Queue holds unread data |
| frame_err | output | 1 | Head entry had a zero first stop bit |
| parity_err | output | 1 | Head entry failed its parity check |
| overrun | output | 1 | A character was lost while the queue was full |

## Verification
The input passes through a two-flop synchroniser. The stop bit is sampled on a tick edge, the finished character is registered on that same edge and written into the queue one edge later, so `rx_ready` and the head fields change one clock after the stop-bit sample. The bench sends the whole stop bit and then two idle bit times before it looks, so every sample falls well after that point. A read strobe driven before an edge changes the head outputs and clears `overrun` at that edge, and a low `rx_en` clears the flags at the first edge. The bench samples these one falling edge later. `overrun` is set at the start-bit confirmation of the next frame, so it is checked only after that whole frame has been sent.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int CHAR_MAX = 9;

  typedef struct packed {
    logic [CHAR_MAX-1:0] data;
    logic                ferr;
    logic                perr;
  } srx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } srx_state_e;

  // size code to number of data bits; unlisted codes mean 8
  function automatic logic [3:0] srx_char_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd5;
      3'd1:    return 4'd6;
      3'd2:    return 4'd7;
      3'd7:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // bits enter at the top of the shifter; move them down to bit 0
  function automatic logic [CHAR_MAX-1:0] srx_align(input logic [CHAR_MAX-1:0] sh,
                                                     input logic [3:0] nbits);
    return sh >> (4'(CHAR_MAX) - nbits);
  endfunction

  // total ones count parity must equal the odd selector
  function automatic logic srx_parity_bad(input logic [CHAR_MAX-1:0] data,
                                          input logic pbit,
                                          input logic odd);
    return (^data ^ pbit) != odd;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                rx_s,
  input  logic [2:0]          csz,
  input  logic [1:0]          pmode,
  input  logic                mp,
  output logic                start_ok,
  output logic                f_done,
  output logic [CHAR_MAX-1:0] f_data,
  output logic                f_ferr,
  output logic                f_perr,
  output logic                f_keep
);

  localparam int CW   = $clog2(OS_RATE);
  localparam int MID  = OS_RATE / 2 - 1;
  localparam int LAST = OS_RATE - 1;

  srx_state_e          st;
  logic [CW-1:0]       cnt;
  logic [3:0]          bidx;
  logic [CHAR_MAX-1:0] sh;
  logic                pbit;
  logic                prev;
  logic [3:0]          nb_l;
  logic                pchk_l;
  logic                podd_l;
  logic                mp_l;

  logic mid_hit;
  logic bit_hit;
  logic fall_seen;
  logic [CHAR_MAX-1:0] aligned;

  assign mid_hit   = tick && (cnt == CW'(MID));
  assign bit_hit   = tick && (cnt == CW'(LAST));
  assign fall_seen = en && tick && prev && !rx_s && (st == ST_IDLE);
  assign start_ok  = en && (st == ST_START) && mid_hit && !rx_s;
  assign aligned   = srx_align(sh, nb_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      prev   <= 1'b1;
      nb_l   <= 4'd8;
      pchk_l <= 1'b0;
      podd_l <= 1'b0;
      mp_l   <= 1'b0;
      f_done <= 1'b0;
      f_data <= '0;
      f_ferr <= 1'b0;
      f_perr <= 1'b0;
      f_keep <= 1'b0;
    end else begin
      f_done <= 1'b0;
      if (tick) prev <= rx_s;
      if (!en) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: begin
            if (fall_seen) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (tick) begin
              if (cnt == CW'(MID)) begin
                cnt <= '0;
                if (rx_s) begin
                  st <= ST_IDLE;
                end else begin
                  st     <= ST_DATA;
                  bidx   <= '0;
                  sh     <= '0;
                  nb_l   <= srx_char_bits(csz);
                  pchk_l <= pmode[1];
                  podd_l <= pmode[0];
                  mp_l   <= mp;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (tick) begin
              if (cnt == CW'(LAST)) begin
                cnt  <= '0;
                sh   <= {rx_s, sh[CHAR_MAX-1:1]};
                bidx <= bidx + 1'b1;
                if (bidx == nb_l - 4'd1) st <= pchk_l ? ST_PAR : ST_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_PAR: begin
            if (tick) begin
              if (cnt == CW'(LAST)) begin
                cnt  <= '0;
                pbit <= rx_s;
                st   <= ST_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_STOP: begin
            if (tick) begin
              if (cnt == CW'(LAST)) begin
                cnt    <= '0;
                st     <= ST_IDLE;
                f_done <= 1'b1;
                f_data <= aligned;
                f_ferr <= !rx_s;
                f_perr <= pchk_l && srx_parity_bad(aligned, pbit, podd_l);
                f_keep <= !mp_l || ((nb_l == 4'd9) ? sh[CHAR_MAX-1] : rx_s);
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) && mid_hit && rx_s |=> st == ST_IDLE); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    f_done |-> (f_data >> nb_l) == '0); // R2

  AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) && !$past(st == ST_STOP) |-> $past(st == ST_DATA) || $past(st == ST_PAR)); // R10

  AST_BIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) && bit_hit && en |=> st != ST_IDLE); // R10

endmodule

// File: rtl/srx_fifo2.sv
module srx_fifo2
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  logic       pop,
  input  srx_entry_t wdata,
  output srx_entry_t head,
  output logic       empty,
  output logic       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  srx_entry_t      mem [DEPTH];
  logic [PW-1:0]   rptr;
  logic [PW-1:0]   wptr;
  logic [CNTW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= wdata;
  end

  assign head  = mem[rptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNTW'(DEPTH));
  assign level = cnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full || pop); // R1

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R1

  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !flush |=> cnt == $past(cnt) - 1'b1); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R7

endmodule

// File: rtl/serial_rx_fifo2.sv
module serial_rx_fifo2
  import srx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic [2:0] char_size,
  input  logic [1:0] parity_mode,
  input  logic       addr_filter,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       rd_bit8,
  output logic       rx_ready,
  output logic       frame_err,
  output logic       parity_err,
  output logic       overrun
);

  localparam int LVW = $clog2(FIFO_DEPTH + 1);

  logic                rx_s;
  logic                start_ok;
  logic                f_done;
  logic [CHAR_MAX-1:0] f_data;
  logic                f_ferr;
  logic                f_perr;
  logic                f_keep;

  srx_entry_t          new_entry;
  srx_entry_t          pend_q;
  logic                pend_v;
  logic                ovr_q;

  srx_entry_t          push_entry;
  srx_entry_t          head;
  logic                fifo_empty;
  logic                fifo_full;
  logic [LVW-1:0]      fifo_level;

  // named events for checking
  logic                pop;
  logic                can_push;
  logic                accept;
  logic                drop_evt;
  logic                ovr_evt;
  logic                push;

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (rx_s)
  );

  srx_frame #(.OS_RATE(OS_RATE)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .tick    (os_tick),
    .rx_s    (rx_s),
    .csz     (char_size),
    .pmode   (parity_mode),
    .mp      (addr_filter),
    .start_ok(start_ok),
    .f_done  (f_done),
    .f_data  (f_data),
    .f_ferr  (f_ferr),
    .f_perr  (f_perr),
    .f_keep  (f_keep)
  );

  assign new_entry  = '{data: f_data, ferr: f_ferr, perr: f_perr};
  assign pop        = rd_strobe && !fifo_empty;
  assign can_push   = !fifo_full || pop;
  assign accept     = f_done && f_keep;
  assign drop_evt   = f_done && !f_keep;
  assign ovr_evt    = start_ok && fifo_full && pend_v && !pop;
  assign push       = can_push && (pend_v || accept);
  assign push_entry = pend_v ? pend_q : new_entry;

  srx_fifo2 #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(!rx_en),
    .push (push),
    .pop  (pop),
    .wdata(push_entry),
    .head (head),
    .empty(fifo_empty),
    .full (fifo_full),
    .level(fifo_level)
  );

  // shift-stage hold and overrun flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_q <= '0;
      ovr_q  <= 1'b0;
    end else if (!rx_en) begin
      pend_v <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (ovr_evt)  ovr_q <= 1'b1;
      else if (pop) ovr_q <= 1'b0;

      if (ovr_evt) begin
        pend_v <= 1'b0;
      end else if (accept && (pend_v || !can_push)) begin
        pend_q <= new_entry;
        pend_v <= 1'b1;
      end else if (pend_v && can_push) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign rx_ready   = !fifo_empty;
  assign rd_data    = fifo_empty ? 8'h00 : head.data[7:0];
  assign rd_bit8    = !fifo_empty && head.data[CHAR_MAX-1];
  assign frame_err  = !fifo_empty && head.ferr;
  assign parity_err = !fifo_empty && head.perr;
  assign overrun    = ovr_q;

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(fifo_full) && $past(pend_v)); // R6

  AST_OVR_CLEARS_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !ovr_evt |=> !ovr_q); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready && !overrun && !frame_err && !parity_err); // R7

  AST_FILTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && !pend_v |=> fifo_level <= $past(fifo_level) && !pend_v); // R8

  AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rx_en && !pop |=> rx_ready); // R3

endmodule

// File: tb/serial_rx_fifo2_test.sv
module serial_rx_fifo2_test;

  localparam int BIT_CLKS = 64;

  typedef struct packed {
    logic [2:0] csz;
    logic [1:0] pm;
    logic       stopv;
    logic       pflip;
    logic [8:0] tx;
    logic [7:0] ed;
    logic       eb8;
    logic       efe;
    logic       epe;
  } vec_t;

  // stimulus and expected head-entry fields
  localparam vec_t VECS [10] = '{
    '{3'd3, 2'd0, 1'b1, 1'b0, 9'h0A5, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{3'd0, 2'd0, 1'b1, 1'b0, 9'h1FF, 8'h1F, 1'b0, 1'b0, 1'b0},
    '{3'd1, 2'd0, 1'b1, 1'b0, 9'h0C3, 8'h03, 1'b0, 1'b0, 1'b0},
    '{3'd2, 2'd0, 1'b1, 1'b0, 9'h0FF, 8'h7F, 1'b0, 1'b0, 1'b0},
    '{3'd7, 2'd0, 1'b1, 1'b0, 9'h155, 8'h55, 1'b1, 1'b0, 1'b0},
    '{3'd3, 2'd2, 1'b1, 1'b0, 9'h03C, 8'h3C, 1'b0, 1'b0, 1'b0},
    '{3'd3, 2'd3, 1'b1, 1'b1, 9'h081, 8'h81, 1'b0, 1'b0, 1'b1},
    '{3'd3, 2'd2, 1'b1, 1'b1, 9'h007, 8'h07, 1'b0, 1'b0, 1'b1},
    '{3'd3, 2'd0, 1'b0, 1'b0, 9'h05A, 8'h5A, 1'b0, 1'b1, 1'b0},
    '{3'd7, 2'd3, 1'b1, 1'b0, 9'h0F0, 8'hF0, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line;
  logic       rx_en;
  logic       os_tick;
  logic [2:0] char_size;
  logic [1:0] parity_mode;
  logic       addr_filter;
  logic       rd_strobe;
  logic [7:0] rd_data;
  logic       rd_bit8;
  logic       rx_ready;
  logic       frame_err;
  logic       parity_err;
  logic       overrun;

  int checks   = 0;
  int failures = 0;
  logic [1:0] tdiv = 2'd0;

  serial_rx_fifo2 uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .rx_en      (rx_en),
    .os_tick    (os_tick),
    .char_size  (char_size),
    .parity_mode(parity_mode),
    .addr_filter(addr_filter),
    .rd_strobe  (rd_strobe),
    .rd_data    (rd_data),
    .rd_bit8    (rd_bit8),
    .rx_ready   (rx_ready),
    .frame_err  (frame_err),
    .parity_err (parity_err),
    .overrun    (overrun)
  );

  always #10 clk = ~clk;

  // one tick every four clocks: sixteen per 64-clock bit
  always @(negedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] code);
    if (code == 3'd7) return 9;
    if (code < 3'd4)  return int'(code) + 5;
    return 8;
  endfunction

  task automatic send_bit(input logic b);
    rx_line = b;
    wait_clks(BIT_CLKS);
  endtask

  task automatic send_frame(input logic [2:0] csz, input logic [1:0] pm,
                            input logic [8:0] d, input logic stopv, input logic pflip);
    int   n;
    logic par;
    n = width_of(csz);
    char_size   = csz;
    parity_mode = pm;
    par = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      send_bit(d[i]);
      par = par ^ d[i];
    end
    if (pm[1]) send_bit(par ^ pm[0] ^ pflip);
    send_bit(stopv);
    rx_line = 1'b1;
    wait_clks(2 * BIT_CLKS);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    wait_clks(1);
    rd_strobe = 1'b0;
  endtask

  initial begin
    rst_n       = 1'b0;
    rx_line     = 1'b1;
    rx_en       = 1'b0;
    os_tick     = 1'b0;
    char_size   = 3'd3;
    parity_mode = 2'd0;
    addr_filter = 1'b0;
    rd_strobe   = 1'b0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);

    // reset state
    chk("R3 reset rx_ready", int'(rx_ready), 0);
    chk("R3 reset rd_data", int'(rd_data), 0);
    chk("R3 reset frame_err", int'(frame_err), 0);
    chk("R3 reset parity_err", int'(parity_err), 0);
    chk("R3 reset overrun", int'(overrun), 0);

    // disabled receiver ignores the line
    send_frame(3'd3, 2'd0, 9'h0AA, 1'b1, 1'b0);
    chk("R7 disabled ignores line", int'(rx_ready), 0);

    rx_en = 1'b1;
    wait_clks(16);

    // table walk: sizes, parity, stop errors
    for (int v = 0; v < 10; v++) begin
      send_frame(VECS[v].csz, VECS[v].pm, VECS[v].tx, VECS[v].stopv, VECS[v].pflip);
      chk($sformatf("R3 vec%0d ready", v), int'(rx_ready), 1);
      chk($sformatf("R2 R10 vec%0d data", v), int'(rd_data), int'(VECS[v].ed));
      chk($sformatf("R2 vec%0d bit8", v), int'(rd_bit8), int'(VECS[v].eb8));
      chk($sformatf("R4 vec%0d frame_err", v), int'(frame_err), int'(VECS[v].efe));
      chk($sformatf("R5 vec%0d parity_err", v), int'(parity_err), int'(VECS[v].epe));
      do_read();
      chk($sformatf("R1 vec%0d popped", v), int'(rx_ready), 0);
    end

    // false start: 4-tick low pulse
    rx_line = 1'b0;
    wait_clks(16);
    rx_line = 1'b1;
    wait_clks(4 * BIT_CLKS);
    chk("R9 false start no char", int'(rx_ready), 0);
    send_frame(3'd3, 2'd0, 9'h03E, 1'b1, 1'b0);
    chk("R9 recovers after false start", int'(rd_data), 8'h3E);
    do_read();

    // order and read on empty
    send_frame(3'd3, 2'd0, 9'h0A1, 1'b1, 1'b0);
    send_frame(3'd3, 2'd0, 9'h0A2, 1'b1, 1'b0);
    chk("R1 first out", int'(rd_data), 8'hA1);
    do_read();
    chk("R1 second out", int'(rd_data), 8'hA2);
    do_read();
    chk("R3 empty after two reads", int'(rx_ready), 0);
    do_read();
    chk("R1 read on empty", int'(rx_ready), 0);
    send_frame(3'd3, 2'd0, 9'h0B7, 1'b1, 1'b0);
    chk("R1 read on empty left queue intact", int'(rd_data), 8'hB7);
    do_read();

    // per-entry frame error status
    send_frame(3'd3, 2'd0, 9'h011, 1'b0, 1'b0);
    send_frame(3'd3, 2'd0, 9'h012, 1'b1, 1'b0);
    chk("R4 head has stop error", int'(frame_err), 1);
    do_read();
    chk("R4 next head clean", int'(frame_err), 0);
    chk("R4 next head data", int'(rd_data), 8'h12);
    do_read();

    // overrun across queue and shift stage
    send_frame(3'd3, 2'd0, 9'h011, 1'b1, 1'b0);
    send_frame(3'd3, 2'd0, 9'h022, 1'b1, 1'b0);
    send_frame(3'd3, 2'd0, 9'h033, 1'b1, 1'b0);
    chk("R6 held char no overrun", int'(overrun), 0);
    chk("R6 full queue ready", int'(rx_ready), 1);
    send_frame(3'd3, 2'd0, 9'h044, 1'b1, 1'b0);
    chk("R6 overrun set", int'(overrun), 1);
    chk("R6 head unchanged", int'(rd_data), 8'h11);
    do_read();
    chk("R6 overrun cleared by read", int'(overrun), 0);
    chk("R6 second entry", int'(rd_data), 8'h22);
    do_read();
    chk("R6 held char lost, newest kept", int'(rd_data), 8'h44);
    do_read();
    chk("R6 queue drained", int'(rx_ready), 0);

    // flush on disable
    send_frame(3'd3, 2'd0, 9'h055, 1'b0, 1'b0);
    send_frame(3'd3, 2'd0, 9'h056, 1'b1, 1'b0);
    rx_en = 1'b0;
    wait_clks(1);
    chk("R7 flush ready", int'(rx_ready), 0);
    chk("R7 flush frame_err", int'(frame_err), 0);
    rx_en = 1'b1;
    wait_clks(16);
    chk("R7 still empty on re-enable", int'(rx_ready), 0);
    send_frame(3'd3, 2'd0, 9'h066, 1'b1, 1'b0);
    chk("R7 fresh data after flush", int'(rd_data), 8'h66);
    do_read();

    // address filtering
    addr_filter = 1'b1;
    send_frame(3'd7, 2'd0, 9'h012, 1'b1, 1'b0);
    chk("R8 9-bit data frame dropped", int'(rx_ready), 0);
    send_frame(3'd7, 2'd0, 9'h1AB, 1'b1, 1'b0);
    chk("R8 9-bit address kept", int'(rd_data), 8'hAB);
    chk("R8 9-bit address bit8", int'(rd_bit8), 1);
    do_read();
    send_frame(3'd3, 2'd0, 9'h077, 1'b0, 1'b0);
    chk("R8 8-bit zero-stop dropped", int'(rx_ready), 0);
    send_frame(3'd3, 2'd0, 9'h078, 1'b1, 1'b0);
    chk("R8 8-bit one-stop kept", int'(rd_data), 8'h78);
    do_read();
    addr_filter = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule